// File: doc/BRIEF.md
# Ripple-Carry ALU with Signed Less-Than

This block is a purely combinational arithmetic and logic unit of parameterised width. It is built from a chain of identical one-bit slices. Each slice can take either B or its complement. It computes an exclusive-or, a not-or and a full-adder sum on that bit, and it picks one of four candidate bits for its result bit. The carry ripples from bit 0 to the top bit. The external carry-in enters bit 0, and the carry leaving the top slice is a block output.

Subtraction is an addition of the complemented B with a carry-in of 1. The signed less-than test runs the same subtraction. The top slice's sum bit, corrected by the signed overflow of the subtraction, is fed back into the result of bit 0, and every higher result bit is forced to 0. Signed overflow is always the exclusive-or of the carries into and out of the top slice.

The block has no clock and no reset. An operation code selects the result path. The B-invert and carry-in controls set the arithmetic mode.

Top module: `rippleAlu`

## Requirements
- R1: With operation code 2'b00, result equals opA XOR the effective B, where the effective B is opB, or ~opB when invertB is 1.
- R2: With operation code 2'b01, result equals NOR(opA, effective B).
- R3: With operation code 2'b10, result equals the low WIDTH bits of opA + effective B + carryIn, and carryOut equals bit WIDTH of that sum.
- R4: invertB complements B for the XOR, NOR and adder paths alike.
- R5: With invertB=1 and carryIn=1, operation code 2'b10 gives opA - opB modulo 2^WIDTH, and carryOut is 1 exactly when opA >= opB unsigned.
- R6: With operation code 2'b11, invertB=1 and carryIn=1, result is 1 when opA < opB as signed two's-complement numbers and 0 otherwise. The result is zero-extended to WIDTH bits, and equal operands give 0.
- R7: overflow equals 1 exactly when the adder's signed sum of opA, effective B and carryIn does not fit in WIDTH bits. This holds for every operation code.
- R8: carryOut reflects the adder for every operation code, not only 2'b10.
- R9: With operation code 2'b11, bits WIDTH-1 down to 1 of result are 0 for any invertB and carryIn. Bit 0 is the adder's top sum bit XOR overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opCode | input | 2 | Result select: 00 XOR, 01 NOR, 10 sum, 11 less-than |
| invertB | input | 1 | Complement B before every path |
| carryIn | input | 1 | Carry into bit 0 |
| result | output | WIDTH | Selected result |
| carryOut | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Signed overflow of the adder |

## Verification
Random operands with random operation codes, invert and carry settings are compared against a reference model of the adder and the logic paths. This checks that the XOR, NOR and sum paths are selected correctly and that the invert control reaches each path. Directed pairs then separate the arithmetic corners. The most negative value minus 1 and the most positive value plus 1 set overflow without a false carry. Equal operands must give 0 from the less-than test. Operands of mixed sign make the less-than result differ from the raw sign bit, which shows that the overflow correction is applied.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_XOR  = 2'b00,
    OP_NOR  = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } aluOp_e;

  typedef struct packed {
    logic selXor;
    logic selNor;
    logic selSum;
    logic selLess;
    logic invB;
    logic cin;
  } aluStrobe_t;
endpackage

// File: rtl/aluSlice.sv
module aluSlice
  import alu_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic lessIn,
  input  logic carryIn,
  input  logic invB,
  input  logic selXor,
  input  logic selNor,
  input  logic selSum,
  input  logic selLess,
  output logic res,
  output logic sumBit,
  output logic carryOut
);
  logic bEff;
  logic xorBit;
  logic norBit;

  always_comb begin
    bEff     = invB ? ~b : b;
    xorBit   = a ^ bEff;
    norBit   = ~(a | bEff);
    sumBit   = xorBit ^ carryIn;
    carryOut = (a & bEff) | (carryIn & xorBit);
    res      = (selXor & xorBit) | (selNor & norBit) |
               (selSum & sumBit) | (selLess & lessIn);
  end

  always_comb begin
    // R4
    invert_path_chk: assert (invB || (xorBit == (a ^ b)));
  end
endmodule

// File: rtl/aluControl.sv
module aluControl
  import alu_pkg::*;
(
  input  logic [1:0]  opCode,
  input  logic        invertB,
  input  logic        carryIn,
  output aluStrobe_t  strobe
);
  always_comb begin
    strobe         = '0;
    strobe.invB    = invertB;
    strobe.cin     = carryIn;
    unique case (aluOp_e'(opCode))
      OP_XOR:  strobe.selXor  = 1'b1;
      OP_NOR:  strobe.selNor  = 1'b1;
      OP_SUM:  strobe.selSum  = 1'b1;
      OP_LESS: strobe.selLess = 1'b1;
      default: strobe.selXor  = 1'b1;
    endcase
  end

  always_comb begin
    // R1
    one_select_chk: assert ($onehot({strobe.selXor, strobe.selNor,
                                      strobe.selSum, strobe.selLess}));
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] lessBits;
  logic             lessValue;

  assign carryChain[0] = strobe.cin;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_slice
      if (gi == 0) begin : g_low
        assign lessBits[gi] = lessValue;
      end else begin : g_high
        assign lessBits[gi] = 1'b0;
      end
      aluSlice u_slice (
        .a        (opA[gi]),
        .b        (opB[gi]),
        .lessIn   (lessBits[gi]),
        .carryIn  (carryChain[gi]),
        .invB     (strobe.invB),
        .selXor   (strobe.selXor),
        .selNor   (strobe.selNor),
        .selSum   (strobe.selSum),
        .selLess  (strobe.selLess),
        .res      (result[gi]),
        .sumBit   (sumBits[gi]),
        .carryOut (carryChain[gi+1])
      );
    end
  endgenerate

  assign carryOut  = carryChain[WIDTH];
  assign overflow  = carryChain[MSB] ^ carryChain[WIDTH];
  assign lessValue = sumBits[MSB] ^ overflow;

  logic [WIDTH-1:0] bRef;
  logic [WIDTH:0]   addRef;
  always_comb begin
    bRef   = strobe.invB ? ~opB : opB;
    addRef = {1'b0, opA} + {1'b0, bRef} + {{WIDTH{1'b0}}, strobe.cin};
    // R3
    sum_match_chk: assert (addRef == {carryOut, sumBits});
    // R6
    less_signed_chk: assert (!(strobe.selLess && strobe.invB && strobe.cin) ||
                             (result == {{(WIDTH-1){1'b0}},
                                         ($signed(opA) < $signed(opB))}));
    // R7
    no_overflow_chk: assert (overflow == ((opA[MSB] == bRef[MSB]) &&
                                          (addRef[MSB] != opA[MSB])));
    // R9
    less_upper_chk: assert (!strobe.selLess || (result[WIDTH-1:1] == '0));
  end
endmodule

// File: rtl/rippleAlu.sv
module rippleAlu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opCode,
  input  logic             invertB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);
  aluStrobe_t strobe;

  aluControl u_ctrl (
    .opCode  (opCode),
    .invertB (invertB),
    .carryIn (carryIn),
    .strobe  (strobe)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow)
  );
endmodule

// File: tb/test_rippleAlu.sv
module test_rippleAlu;
  localparam int WIDTH = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};

  logic clk = 1'b0;
  logic [WIDTH-1:0] opA, opB, result;
  logic [1:0] opCode;
  logic invertB, carryIn, carryOut, overflow;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rippleAlu #(.WIDTH(WIDTH)) i_rippleAlu (
    .opA(opA), .opB(opB), .opCode(opCode), .invertB(invertB),
    .carryIn(carryIn), .result(result), .carryOut(carryOut),
    .overflow(overflow)
  );

  function automatic logic [WIDTH+1:0] refModel(
      input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
      input logic [1:0] op, input logic inv, input logic ci);
    logic [WIDTH-1:0] be, res;
    logic [WIDTH:0] full;
    logic ov;
    be   = inv ? ~b : b;
    full = {1'b0, a} + {1'b0, be} + {{WIDTH{1'b0}}, ci};
    ov   = (a[WIDTH-1] == be[WIDTH-1]) && (full[WIDTH-1] != a[WIDTH-1]);
    case (op)
      2'b00:   res = a ^ be;
      2'b01:   res = ~(a | be);
      2'b10:   res = full[WIDTH-1:0];
      default: res = {{(WIDTH-1){1'b0}}, full[WIDTH-1] ^ ov};
    endcase
    return {full[WIDTH], ov, res};
  endfunction

  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic [1:0] op, input logic inv, input logic ci);
    @(posedge clk);
    opA = a; opB = b; opCode = op; invertB = inv; carryIn = ci;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [WIDTH+1:0] got,
                       input logic [WIDTH+1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic modelCheck(input string req);
    check(req, {carryOut, overflow, result},
          refModel(opA, opB, opCode, invertB, carryIn));
  endtask

  initial begin
    opA = '0; opB = '0; opCode = 2'b00; invertB = 1'b0; carryIn = 1'b0;
    void'($urandom(32'h5eed1234));

    // idle inputs: XOR of zeros
    apply('0, '0, 2'b00, 1'b0, 1'b0);
    check("R1 idle", {carryOut, overflow, result}, '0);

    // R1 R2 R4 directed
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b00, 1'b0, 1'b0);
    check("R1 xor", {2'b00, result}, {2'b00, 32'hF0F0_1234 ^ 32'h0FF0_FFFF});
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b01, 1'b0, 1'b0);
    check("R2 nor", {2'b00, result}, {2'b00, ~(32'hF0F0_1234 | 32'h0FF0_FFFF)});
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b00, 1'b1, 1'b0);
    check("R4 xor inverted", {2'b00, result}, {2'b00, 32'hF0F0_1234 ^ 32'hF00F_0000});
    apply(32'h0000_0001, 32'hFFFF_FFFE, 2'b01, 1'b1, 1'b0);
    check("R4 nor inverted", {2'b00, result}, {2'b00, 32'hFFFF_FFFE});

    // R3 R8 carry out
    apply(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b0, 1'b0);
    check("R3 wrap", {carryOut, overflow, result}, {2'b10, 32'h0});
    apply(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b0, 1'b0);
    check("R8 carry under xor", {carryOut, 1'b0, 32'h0}, {1'b1, 1'b0, 32'h0});

    // R5 R7 subtraction corners
    apply(MIN_NEG, 32'd1, 2'b10, 1'b1, 1'b1);
    check("R5 R7 minneg-1", {carryOut, overflow, result}, {2'b11, MAX_POS});
    apply(MAX_POS, 32'd1, 2'b10, 1'b0, 1'b0);
    check("R7 maxpos+1", {carryOut, overflow, result}, {2'b01, MIN_NEG});
    apply(32'd5, 32'd9, 2'b10, 1'b1, 1'b1);
    check("R5 borrow", {carryOut, overflow, result}, {2'b00, 32'd5 - 32'd9});
    apply(32'd9, 32'd9, 2'b10, 1'b1, 1'b1);
    check("R5 equal", {carryOut, overflow, result}, {2'b10, 32'd0});

    // R6 less-than corners
    apply(32'd77, 32'd77, 2'b11, 1'b1, 1'b1);
    check("R6 equal", {2'b00, result}, {2'b00, 32'd0});
    apply(MIN_NEG, 32'd1, 2'b11, 1'b1, 1'b1);
    check("R6 minneg<1", {2'b00, result}, {2'b00, 32'd1});
    apply(32'd1, MIN_NEG, 2'b11, 1'b1, 1'b1);
    check("R6 1<minneg", {2'b00, result}, {2'b00, 32'd0});
    apply(32'hFFFF_FFFF, 32'd0, 2'b11, 1'b1, 1'b1);
    check("R6 -1<0", {2'b00, result}, {2'b00, 32'd1});
    apply(MAX_POS, 32'hFFFF_FFFF, 2'b11, 1'b1, 1'b1);
    check("R6 maxpos<-1", {2'b00, result}, {2'b00, 32'd0});

    // R9 less-than with other controls
    apply(32'h8000_0000, 32'h8000_0000, 2'b11, 1'b0, 1'b0);
    modelCheck("R9 add mode");

    // random sweep over all codes R1 R2 R3 R4 R7 R8 R9
    for (int i = 0; i < 3000; i++) begin
      logic [WIDTH-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) rb = ra;
      apply(ra, rb, 2'($urandom()), 1'($urandom()), 1'($urandom()));
      modelCheck("R1 R2 R3 R4 R7 R8 R9 random");
      if (opCode == 2'b11 && invertB && carryIn)
        check("R6 random", {2'b00, result},
              {2'b00, {(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))});
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule